// File: doc/BRIEF.md
# Buzzer Tone Generator with Duty Select

This block drives a complementary pair of buzzer pins with a square tone for alarms, fixed tones or melodies. A reload counter counts source ticks. Each time it reaches zero it reloads from the programmed frequency value and steps a segment counter. One tone period is made of N segments, and each segment lasts (F+1) ticks. The first segment of each period is the high phase, so the output duty is 1/N. A 2-bit duty code chooses N.

Ticks come from one of two sources, selected by a configuration bit. With the bit set, every system clock cycle is a tick. With the bit clear, only cycles with the slow predivider tap strobe are ticks.

An 8-bit envelope down-counter sets how long the tone sounds. It drops by one at the end of every completed tone period, and the pins go silent when it reaches zero. Melody software rewrites the frequency and duty between notes, and reloads the envelope for each note.

Top module: `bz_tone_top`

## Requirements
- R1: After synchronous reset both pins are low and the envelope count is zero, so enabling the block without loading an envelope keeps both pins low.
- R2: While `en` is low, both pins are low from the next clock on, and the divider restarts at the beginning of the high segment when `en` returns high.
- R3: With `src_sel`=1, every clock is a tick. After the first enabled clock edge, the pins follow a period of N*(F+1) clocks, with `bz` high for the first F+1 clocks of each period. F is `freq_val`.
- R4: The duty code `duty_sel` sets N: 2'b00 gives N=4, 2'b01 gives N=3, 2'b10 gives N=2, and the reserved 2'b11 gives N=2.
- R5: With `src_sel`=0, the divider advances only on clock edges where `slow_tick` is 1, and holds its state on all other edges.
- R6: A new `freq_val` takes effect at the next reload (the tick on which the count is zero). The segment already in progress keeps its length.
- R7: A new `duty_sel` takes effect only at the start of the next tone period.
- R8: A one-cycle `env_load` sets the envelope count to `env_val`. The count decrements once per completed tone period. Once it is zero, both pins stay low, and a loaded value of 0 gives silence.
- R9: While sounding, `bzb` is the complement of `bz`. The two pins are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Tone enable; low holds both pins low and restarts the divider |
| src_sel | input | 1 | Tick source: 1 = every clock, 0 = slow tap strobe |
| slow_tick | input | 1 | One-cycle strobe from the slow predivider tap |
| freq_val | input | FREQ_W | Reload value F; a segment lasts F+1 ticks |
| duty_sel | input | 2 | Duty code (00 = 1/4, 01 = 1/3, 10 or 11 = 1/2) |
| env_load | input | 1 | Loads the envelope count from env_val |
| env_val | input | ENV_W | Envelope length in tone periods |
| bz | output | 1 | Buzzer pin, registered |
| bzb | output | 1 | Complementary buzzer pin, registered |

## Verification
The bench uses the default 8-bit frequency and envelope widths. It sweeps every reload value from 0 to 15 against all four duty codes with an envelope of two periods, so it covers every duty variant, the one-tick segment case and the exact cycle on which the envelope silences the pins. A single run at reload value 255 exercises the full counter width. Further directed runs cover the slow-strobe source, a frequency change during a segment, a duty change during a period, a zero envelope and a restart after disable, each checked cycle by cycle against closed-form arithmetic.

// File: rtl/bz_tone_pkg.sv
package bz_tone_pkg;
  typedef enum logic [1:0] {
    DUTY_QUARTER = 2'b00,
    DUTY_THIRD   = 2'b01,
    DUTY_HALF    = 2'b10,
    DUTY_RSVD    = 2'b11
  } duty_e;

  localparam int SEG_W = 2;

  // index of the final segment in one tone period
  function automatic logic [SEG_W-1:0] final_seg(input duty_e d);
    case (d)
      DUTY_QUARTER: final_seg = 2'd3;
      DUTY_THIRD:   final_seg = 2'd2;
      default:      final_seg = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/bz_tone_div.sv
module bz_tone_div
  import bz_tone_pkg::*;
#(
  parameter int FREQ_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic [FREQ_W-1:0] freq_in,
  input  duty_e             duty_in,
  output logic              high_seg,
  output logic              period_done
);
  logic [FREQ_W-1:0] cnt;
  logic [SEG_W-1:0]  seg;
  duty_e             duty_q;
  logic              at_zero;
  logic              at_last;

  assign at_zero     = (cnt == '0);
  assign at_last     = (seg == final_seg(duty_q));
  assign period_done = en && tick && at_zero && at_last;
  assign high_seg    = (seg == '0);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt    <= freq_in;
      seg    <= '0;
      duty_q <= duty_in;
    end else if (tick) begin
      if (at_zero) begin
        cnt <= freq_in;
        if (at_last) begin
          seg    <= '0;
          duty_q <= duty_in;
        end else begin
          seg <= seg + 1'b1;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  p_seg_range_r4: assert property (@(posedge clk) disable iff (rst)
    seg <= final_seg(duty_q));
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (en && tick && at_zero) |=> (cnt == $past(freq_in)));
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> ($stable(cnt) && $stable(seg)));
endmodule

// File: rtl/bz_tone_env.sv
module bz_tone_env #(
  parameter int ENV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ENV_W-1:0] val,
  input  logic             step,
  output logic             alive
);
  logic [ENV_W-1:0] env;

  assign alive = (env != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      env <= '0;
    end else if (load) begin
      env <= val;
    end else if (step && alive) begin
      env <= env - 1'b1;
    end
  end

  p_zero_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && !alive) |=> !alive);
  p_step_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && step && alive) |=> (env == $past(env) - 1'b1));
endmodule

// File: rtl/bz_tone_pins.sv
module bz_tone_pins (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic alive,
  input  logic high_seg,
  output logic bz,
  output logic bzb
);
  logic sound;

  assign sound = en && alive;

  always_ff @(posedge clk) begin
    if (rst) begin
      bz  <= 1'b0;
      bzb <= 1'b0;
    end else begin
      bz  <= sound && high_seg;
      bzb <= sound && !high_seg;
    end
  end

  p_pins_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(bz && bzb));
  p_disabled_low_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!bz && !bzb));
endmodule

// File: rtl/bz_tone_top.sv
module bz_tone_top
  import bz_tone_pkg::*;
#(
  parameter int FREQ_W = 8,
  parameter int ENV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              src_sel,
  input  logic              slow_tick,
  input  logic [FREQ_W-1:0] freq_val,
  input  logic [1:0]        duty_sel,
  input  logic              env_load,
  input  logic [ENV_W-1:0]  env_val,
  output logic              bz,
  output logic              bzb
);
  logic  tick;
  logic  high_seg;
  logic  period_done;
  logic  alive;
  duty_e duty_in;

  assign tick    = src_sel ? 1'b1 : slow_tick;
  assign duty_in = duty_e'(duty_sel);

  bz_tone_div #(.FREQ_W(FREQ_W)) u_div (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .tick        (tick),
    .freq_in     (freq_val),
    .duty_in     (duty_in),
    .high_seg    (high_seg),
    .period_done (period_done)
  );

  bz_tone_env #(.ENV_W(ENV_W)) u_env (
    .clk   (clk),
    .rst   (rst),
    .load  (env_load),
    .val   (env_val),
    .step  (period_done),
    .alive (alive)
  );

  bz_tone_pins u_pins (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .alive    (alive),
    .high_seg (high_seg),
    .bz       (bz),
    .bzb      (bzb)
  );
endmodule

// File: tb/bz_tone_top_tb.sv
module bz_tone_top_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       en;
  logic       src_sel;
  logic       slow_tick;
  logic [7:0] freq_val;
  logic [1:0] duty_sel;
  logic       env_load;
  logic [7:0] env_val;
  logic       bz;
  logic       bzb;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  bz_tone_top u_dut (
    .clk(clk), .rst(rst), .en(en), .src_sel(src_sel), .slow_tick(slow_tick),
    .freq_val(freq_val), .duty_sel(duty_sel), .env_load(env_load),
    .env_val(env_val), .bz(bz), .bzb(bzb)
  );

  function automatic int segs_of(input int code);
    return (code == 0) ? 4 : (code == 1) ? 3 : 2;
  endfunction

  task automatic chk(input bit ebz, input bit ebzb, input string req);
    n_run++;
    if (bz !== ebz || bzb !== ebzb) begin
      n_fail++;
      $display("FAIL %s: bz/bzb got %b%b expected %b%b at %0t", req, bz, bzb, ebz, ebzb, $time);
    end
  endtask

  // disable, load envelope, set config; ends at a negedge with en low
  task automatic setup(input int f, input int code, input int e, input bit src);
    en = 0; src_sel = src; freq_val = 8'(f); duty_sel = 2'(code);
    env_val = 8'(e); env_load = 1; slow_tick = 0;
    @(posedge clk); @(negedge clk);
    env_load = 0;
    @(posedge clk); @(negedge clk);
  endtask

  // sweep: k = ticks before the edge just passed
  task automatic run_cfg(input int f, input int code, input int e, input bit src, input string req);
    int n = segs_of(code);
    int lim = e * n * (f + 1);
    int k = 0;
    int cyc = 0;
    bit tk;
    setup(f, code, e, src);
    en = 1;
    tk = src ? 1'b1 : 1'b1;
    slow_tick = tk;
    while (k < lim + 3) begin
      bit act, hi;
      @(posedge clk); @(negedge clk);
      act = (k < lim);
      hi  = ((k / (f + 1)) % n) == 0;
      chk(act && hi, act && !hi, req);
      k += tk;
      cyc++;
      tk = src ? 1'b1 : ((cyc % 3) == 0);
      slow_tick = tk;
    end
    en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, got running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; en = 0; src_sel = 1; slow_tick = 0; freq_val = 0;
    duty_sel = 0; env_load = 0; env_val = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(0, 0, "R1 reset state");
    rst = 0;
    // R1: enabled with no envelope load stays silent
    en = 1; freq_val = 8'd2; duty_sel = 2'b10;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); @(negedge clk);
      chk(0, 0, "R1 no envelope after reset");
    end
    en = 0;

    // R3/R4/R8/R9 sweep on the system clock source
    for (int f = 0; f < 16; f++)
      for (int code = 0; code < 4; code++)
        run_cfg(f, code, 2, 1'b1, "R3 R4 R8 R9 sweep");
    run_cfg(255, 2, 1, 1'b1, "R3 full-width reload");
    run_cfg(0, 0, 1, 1'b1, "R8 single period");

    // R5 slow strobe source
    run_cfg(1, 1, 2, 1'b0, "R5 slow source");
    run_cfg(3, 3, 1, 1'b0, "R5 R4 slow source reserved duty");

    // R8 zero envelope
    setup(2, 2, 0, 1'b1);
    en = 1;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      chk(0, 0, "R8 zero envelope silent");
    end

    // R6 frequency change mid-segment: F 3 -> 1, half duty
    setup(3, 2, 50, 1'b1);
    en = 1;
    for (int k = 0; k < 24; k++) begin
      int s;
      @(posedge clk); @(negedge clk);
      s = (k <= 3) ? 0 : 1 + (k - 4) / 2;
      chk((s % 2) == 0, (s % 2) != 0, "R6 new frequency at reload");
      if (k == 1) freq_val = 8'd1;
    end

    // R7 duty change mid-period: quarter -> half, F=1
    setup(1, 0, 50, 1'b1);
    en = 1;
    for (int k = 0; k < 24; k++) begin
      int s;
      bit hi;
      @(posedge clk); @(negedge clk);
      s = k / 2;
      hi = (s < 4) ? (s == 0) : (((s - 4) % 2) == 0);
      chk(hi, !hi, "R7 duty change at period start");
      if (k == 3) duty_sel = 2'b10;
    end

    // R2 disable mid-tone, then restart at high segment
    setup(2, 1, 50, 1'b1);
    en = 1;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); @(negedge clk);
      chk(k < 3, k >= 3, "R2 R9 before disable");
    end
    en = 0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
      chk(0, 0, "R2 disabled pins low");
    end
    en = 1;
    for (int k = 0; k < 9; k++) begin
      @(posedge clk); @(negedge clk);
      chk(k < 3, k >= 3, "R2 restart at high segment");
    end
    en = 0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule